// File: doc/BRIEF.md
# Failover Watchdog Countdown Timer

This block is a down-counter that software loads and that then runs out on its own. A prescaler divides the system clock into a one-microsecond step. On each step the count drops by one as long as it is above zero. When a step takes the count from one to zero, the block raises an expiry pulse for exactly one clock cycle. Logic elsewhere uses that pulse to decide on a failover; that logic is not part of this block.

Software rearms the timer by writing a new count, and may do so at any moment. Every write also restarts the prescaler, so the first step after a load lasts a full microsecond. At zero the count stays where it is and never wraps. Loading zero disarms the timer without a pulse. The count is 32 bits wide, which allows a little over 71 minutes at one step per microsecond. A hot reset does not touch the timer, so a countdown that is still running carries on through it. Only the cold reset clears the count.

Top module: `fowd_timer`

## Requirements
- R1: While the cold reset `rst` is high at a clock edge, the count is cleared to 0 and `expire_o` is held low after that edge.
- R2: While the count is non-zero and no write takes place, the count falls by exactly one every `TICK_DIV` clock cycles. The first fall comes `TICK_DIV` edges after the edge that performed the write.
- R3: Once the count is zero it stays zero until the next write. No further pulses follow, and the count never wraps to the maximum value.
- R4: `expire_o` is high for exactly one cycle. That cycle is the first one in which `count_o` reads 0 after a timed step from 1, so pulse and zero appear on the same edge.
- R5: A write (`wr_en_i` high at an edge) loads `wr_data_i` into the count and shows it on `count_o` after that edge, whatever the old count was. A write of 0 produces no pulse.
- R6: If a write falls on the same edge as a timed step, the written value is loaded unchanged, no pulse is produced, and the next step follows a full `TICK_DIV` cycles later.
- R7: `hot_rst_i` has no effect. The count values and the pulse cycle are the same as when it is held low.
- R8: The count holds the full 32-bit range. A write of 0xFFFFFFFF reads back unchanged and steps to 0xFFFFFFFE after `TICK_DIV` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Cold reset, synchronous, active high |
| hot_rst_i | input | 1 | Hot reset indication, has no effect on this block |
| wr_en_i | input | 1 | Count write strobe |
| wr_data_i | input | CNT_W | Value to load into the count |
| count_o | output | CNT_W | Current count, registered |
| expire_o | output | 1 | One-cycle pulse on the step from one to zero |

## Verification
A software write and a prescaler step can fall on the same clock edge. The bench causes this by timing a write so that it lands exactly `TICK_DIV` edges after the previous load, which is the edge where a step is due. In one case the new value differs from the stepped value, and `count_o` must show the written value. In the other case the count is one and the write loads one, so the bench checks that no pulse appears and that the expected pulse arrives one full period later.

// File: rtl/fowd_pkg.sv
package fowd_pkg;
  localparam int unsigned FOWD_CNT_W    = 32;
  localparam int unsigned FOWD_TICK_DIV = 125;

  typedef enum logic [1:0] {
    CNT_HOLD = 2'd0,
    CNT_LOAD = 2'd1,
    CNT_STEP = 2'd2
  } cnt_op_e;
endpackage

// File: rtl/fowd_prescale.sv
module fowd_prescale #(
  parameter int unsigned TICK_DIV = fowd_pkg::FOWD_TICK_DIV
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  output logic tick_o
);
  generate
    if (TICK_DIV < 2) begin : g_pass
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam int unsigned PW = $clog2(TICK_DIV);
      localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);
      logic [PW-1:0] pre_q;

      always_ff @(posedge clk) begin
        if (rst || clr_i) begin
          pre_q <= '0;
        end else if (pre_q == LAST) begin
          pre_q <= '0;
        end else begin
          pre_q <= pre_q + 1'b1;
        end
      end

      assign tick_o = (pre_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/fowd_count.sv
module fowd_count
  import fowd_pkg::*;
#(
  parameter int unsigned CNT_W = FOWD_CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] count_o,
  output logic             expire_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             exp_q;
  cnt_op_e          op;

  always_comb begin
    if (load_i) begin
      op = CNT_LOAD;
    end else if (tick_i && (cnt_q != '0)) begin
      op = CNT_STEP;
    end else begin
      op = CNT_HOLD;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      exp_q <= 1'b0;
    end else begin
      exp_q <= (op == CNT_STEP) && (cnt_q == ONE);
      case (op)
        CNT_LOAD: cnt_q <= load_val_i;
        CNT_STEP: cnt_q <= cnt_q - ONE;
        default:  cnt_q <= cnt_q;
      endcase
    end
  end

  assign count_o  = cnt_q;
  assign expire_o = exp_q;
endmodule

// File: rtl/fowd_timer.sv
module fowd_timer
  import fowd_pkg::*;
#(
  parameter int unsigned CNT_W    = FOWD_CNT_W,
  parameter int unsigned TICK_DIV = FOWD_TICK_DIV
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hot_rst_i,
  input  logic             wr_en_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic [CNT_W-1:0] count_o,
  output logic             expire_o
);
  logic tick;

  fowd_prescale #(
    .TICK_DIV(TICK_DIV)
  ) u_prescale (
    .clk   (clk),
    .rst   (rst),
    .clr_i (wr_en_i),
    .tick_o(tick)
  );

  fowd_count #(
    .CNT_W(CNT_W)
  ) u_count (
    .clk       (clk),
    .rst       (rst),
    .load_i    (wr_en_i),
    .load_val_i(wr_data_i),
    .tick_i    (tick),
    .count_o   (count_o),
    .expire_o  (expire_o)
  );
endmodule

// File: rtl/fowd_timer_chk.sv
module fowd_timer_chk #(
  parameter int unsigned CNT_W    = 32,
  parameter int unsigned TICK_DIV = 125
) (
  input logic             clk,
  input logic             rst,
  input logic             hot_rst_i,
  input logic             wr_en_i,
  input logic [CNT_W-1:0] wr_data_i,
  input logic [CNT_W-1:0] count_o,
  input logic             expire_o
);
  localparam int unsigned GW = $clog2(TICK_DIV + 1) + 1;
  localparam logic [GW-1:0] GLAST = GW'(TICK_DIV - 1);

  logic [GW-1:0] gap_q;

  always_ff @(posedge clk) begin
    if (rst || wr_en_i || (gap_q == GLAST) || (TICK_DIV < 2)) begin
      gap_q <= '0;
    end else begin
      gap_q <= gap_q + 1'b1;
    end
  end

  AST_COLD_CLEAR: assert property (@(posedge clk)
    rst |=> (count_o == '0) && !expire_o); // R1

  AST_STEP_TIMING: assert property (@(posedge clk) disable iff (rst)
    (!wr_en_i && count_o != '0) |=>
      ((count_o == $past(count_o) - 1) == ($past(gap_q) == GLAST))); // R2

  AST_STEP_SIZE: assert property (@(posedge clk) disable iff (rst)
    (!wr_en_i && count_o != '0) |=>
      ((count_o == $past(count_o)) || (count_o == $past(count_o) - 1))); // R2

  AST_ZERO_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!wr_en_i && count_o == '0) |=> (count_o == '0) && !expire_o); // R3

  AST_PULSE_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    expire_o |-> (count_o == '0) && ($past(count_o) == 1) && !$past(wr_en_i)); // R4

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    expire_o |=> !expire_o); // R4

  AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (rst)
    wr_en_i |=> (count_o == $past(wr_data_i)) && !expire_o); // R5

  AST_HOT_NO_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (hot_rst_i && !wr_en_i && count_o > 1) |=> (count_o != '0)); // R7
endmodule

bind fowd_timer fowd_timer_chk #(
  .CNT_W   (CNT_W),
  .TICK_DIV(TICK_DIV)
) u_fowd_timer_chk (
  .clk      (clk),
  .rst      (rst),
  .hot_rst_i(hot_rst_i),
  .wr_en_i  (wr_en_i),
  .wr_data_i(wr_data_i),
  .count_o  (count_o),
  .expire_o (expire_o)
);

// File: tb/fowd_timer_bench.sv
module fowd_timer_bench;
  localparam int unsigned CW  = 32;
  localparam int unsigned DIV = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          hot_rst = 1'b0;
  logic          wr_en = 1'b0;
  logic [CW-1:0] wr_data = '0;
  logic [CW-1:0] count;
  logic          expire;

  int unsigned cyc = 0;
  int unsigned n_chk = 0;
  int unsigned n_bad = 0;
  int unsigned w_cyc = 0;
  bit          done = 1'b0;
  int unsigned exp_q[$];

  always #4 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  fowd_timer #(
    .CNT_W   (CW),
    .TICK_DIV(DIV)
  ) u_fowd_timer (
    .clk      (clk),
    .rst      (rst),
    .hot_rst_i(hot_rst),
    .wr_en_i  (wr_en),
    .wr_data_i(wr_data),
    .count_o  (count),
    .expire_o (expire)
  );

  // Monitor: every pulse must match the head of the expected queue.
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (expire) begin
        n_chk++;
        if (exp_q.size() != 0 && exp_q[0] == cyc) begin
          void'(exp_q.pop_front());
        end else begin
          n_bad++;
          $display("FAIL R4: pulse at cycle %0d, expected %0d",
                   cyc, (exp_q.size() != 0) ? exp_q[0] : 0);
          if (exp_q.size() != 0) void'(exp_q.pop_front());
        end
      end else if (exp_q.size() != 0 && exp_q[0] <= cyc) begin
        n_chk++;
        n_bad++;
        $display("FAIL R4: pulse missing, actual none at cycle %0d expected %0d",
                 cyc, exp_q[0]);
        void'(exp_q.pop_front());
      end
    end
  end

  task automatic chk(input string tag, input logic [CW-1:0] exp_cnt);
    n_chk++;
    if (count !== exp_cnt) begin
      n_bad++;
      $display("FAIL %s: count actual %0d expected %0d", tag, count, exp_cnt);
    end
  endtask

  task automatic chk_low(input string tag);
    n_chk++;
    if (expire !== 1'b0) begin
      n_bad++;
      $display("FAIL %s: expire actual %b expected 0", tag, expire);
    end
  endtask

  task automatic wait_cyc(input int unsigned n);
    repeat (n) @(negedge clk);
  endtask

  // Driver: performs a write and returns at the negedge just after it.
  task automatic do_write(input logic [CW-1:0] val, input bit expect_pulse);
    wr_en   = 1'b1;
    wr_data = val;
    w_cyc   = cyc;
    if (expect_pulse && val != 0) exp_q.push_back(w_cyc + 1 + val * DIV);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    finish_run();
  end

  initial begin
    wait_cyc(3);
    chk("R1", 0);
    chk_low("R1");
    rst = 1'b0;
    wait_cyc(2);

    // Basic countdown of 3 steps.
    do_write(3, 1'b1);
    chk("R5", 3);
    wait_cyc(DIV - 1);
    chk("R2", 3);
    wait_cyc(1);
    chk("R2", 2);
    wait_cyc(2 * DIV);
    chk("R4", 0);
    wait_cyc(4 * DIV);
    chk("R3", 0);
    chk_low("R3");

    // Write of zero: no pulse.
    do_write(0, 1'b0);
    chk("R5", 0);
    wait_cyc(3 * DIV);
    chk("R5", 0);

    // Rearm mid-count: only the second load's expiry is expected.
    do_write(5, 1'b0);
    wait_cyc(2 * DIV + 3);
    chk("R2", 3);
    do_write(4, 1'b1);
    chk("R5", 4);
    wait_cyc(4 * DIV + 2);
    chk("R5", 0);

    // Write on a step edge with a different value.
    do_write(2, 1'b0);
    wait_cyc(DIV - 1);
    do_write(7, 1'b0);
    chk("R6", 7);
    wait_cyc(DIV - 1);
    chk("R6", 7);
    wait_cyc(1);
    chk("R6", 6);

    // Write of one on the edge where one would step to zero.
    do_write(1, 1'b0);
    wait_cyc(DIV - 1);
    do_write(1, 1'b1);
    chk("R6", 1);
    chk_low("R6");
    wait_cyc(DIV + 2);
    chk("R6", 0);

    // Hot reset held across steps has no effect.
    do_write(3, 1'b1);
    hot_rst = 1'b1;
    wait_cyc(DIV + 2);
    chk("R7", 2);
    wait_cyc(DIV);
    chk("R7", 1);
    hot_rst = 1'b0;
    wait_cyc(DIV + 2);
    chk("R7", 0);

    // Cold reset in the middle of a countdown.
    do_write(5, 1'b0);
    wait_cyc(DIV + 1);
    rst = 1'b1;
    wait_cyc(1);
    chk("R1", 0);
    rst = 1'b0;
    wait_cyc(6 * DIV);
    chk("R1", 0);

    // Full-width load.
    do_write(32'hFFFF_FFFF, 1'b0);
    chk("R8", 32'hFFFF_FFFF);
    wait_cyc(DIV);
    chk("R8", 32'hFFFF_FFFE);
    rst = 1'b1;
    wait_cyc(2);
    rst = 1'b0;
    wait_cyc(2);

    n_chk++;
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R4: pending pulses actual %0d expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule